// File: doc/BRIEF.md
# Prescaled Up/Down Timer with Lockable Watchdog

This block is a 16-bit counter on a small register bus that serves either as a general timer or as a system watchdog. Software sets a load value, picks the count direction, a source-clock divider (1, 16 or 256) and a reload policy, and then enables the counter. In the default free-running policy the count wraps through the whole 16-bit range. In the periodic policy it reloads from the load register each time it expires. Each expiry raises a level interrupt that stays high until software writes the clear register.

With watchdog mode on, an expiry either pulses a one-cycle reset request, which also returns every register of the block to its reset value, or raises the interrupt instead. Software must keep writing the clear register to restart the timeout. An optional secure-clear check accepts a clear only when its data equals the next value of an 8-bit pseudo-random sequence. Any other data triggers the watchdog action at once. While the watchdog is running, the control register cannot be changed.

Top module: `wdog_timer`

## Requirements
- R1: After reset the load register reads 0x0000, the count reads 0xFFFF, control reads 0x0000, and both `irq` and `rst_req` are low.
- R2: Word addresses: 0 is load (read/write), 1 is count (read-only, writes ignored), 2 is control (read/write), and 3 is clear (write-only, reads 0). Control fields are: bit 8 up, bit 7 enable, bit 6 periodic, bit 5 watchdog, bit 4 secure clear, bits 3:2 prescale, and bit 1 watchdog-to-interrupt. Bits 15:9 and bit 0 read 0. `bus_rdata` is 0 while `bus_re` is low.
- R3: A control write that sets enable while the counter is disabled loads the count from the load register and restarts the prescaler. While disabled, the count holds its value.
- R4: Prescale code 01 gives one count step every 16 clocks and code 10 every 256 clocks, the first step coming a full period after the load. Codes 00 and 11 give one step every clock.
- R5: Counting down, a step that finds the count at 0x0000 is an expiry. Free-running wraps to 0xFFFF; periodic reloads the load value.
- R6: Counting up, a step that finds the count at 0xFFFF is an expiry. Free-running wraps to 0x0000; periodic reloads the load value.
- R7: `irq` goes high in the cycle after an expiry and stays high until a write to the clear register. If both happen in the same cycle, the set wins.
- R8: In watchdog mode with bit 1 clear, an expiry drives `rst_req` high for exactly one cycle. In that same cycle every register of the block holds its reset value.
- R9: In watchdog mode with bit 1 set, an expiry raises `irq` and no reset request.
- R10: In watchdog mode without secure clear, any write to the clear register reloads the count from the load register and restarts the prescaler.
- R11: With secure clear, an 8-bit state starts at 0xA5 and its next value is {s[6:0], s[7]^s[5]^s[4]^s[3]}. A clear whose low byte equals that next value restarts the watchdog and advances the state. Any other byte triggers the watchdog action immediately.
- R12: While enable and watchdog are both set, control writes are ignored until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Expiry interrupt level |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest state to reach from the ports is a secure-clear mismatch while the watchdog is armed. Reaching it requires the bench to track the pseudo-random sequence itself and to time the clear writes against a running count. The bench first sends the correct first value and confirms the restart by reading back the reloaded count. It then sends a wrong second value and expects the reset pulse in the following cycle. The same path is repeated with the interrupt action selected. The control lock is reached by arming the watchdog and attempting a disabling write before the expiry that it would otherwise need to survive.

// File: rtl/wdt_pkg.sv
// Package: shared control-word type and address codes for the watchdog timer.
// Assumes the control fields occupy word bits 8:1 in the order of ctrl_t.
package wdt_pkg;

    typedef struct packed {
        logic       up;
        logic       en;
        logic       periodic;
        logic       wd;
        logic       secure;
        logic [1:0] presc;
        logic       wd_irq;
    } ctrl_t;

    typedef enum logic [1:0] {
        A_LOAD  = 2'd0,
        A_COUNT = 2'd1,
        A_CTRL  = 2'd2,
        A_CLEAR = 2'd3
    } addr_e;

    // Pack the control fields into a 16-bit bus word, reserved bits zero.
    function automatic logic [15:0] ctrl_to_word(ctrl_t c);
        return {7'b0, c, 1'b0};
    endfunction

    // Extract the control fields from a 16-bit bus word.
    function automatic ctrl_t word_to_ctrl(logic [15:0] w);
        return ctrl_t'(w[8:1]);
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
// Prescaler: emits a one-cycle tick every 1, 2**SHIFT_MID or 2**SHIFT_HI
// clocks while run is high. Assumes restart and clr take priority over run.
module wdt_prescale #(
    parameter int SHIFT_MID = 4,
    parameter int SHIFT_HI  = 8,
    localparam int PW       = SHIFT_HI
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam logic [PW-1:0] LIM_MID = PW'((1 << SHIFT_MID) - 1);
    localparam logic [PW-1:0] LIM_HI  = PW'((1 << SHIFT_HI) - 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    // Decode the divider code; 11 behaves as 00.
    always_comb begin
        case (sel)
            2'b01:   limit = LIM_MID;
            2'b10:   limit = LIM_HI;
            default: limit = '0;
        endcase
    end

    assign tick = run && (pcnt >= limit);

    // Advance the prescale count, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || restart) pcnt <= '0;
        else if (run)                 pcnt <= tick ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/wdt_lfsr.sv
// Sequence generator for secure clear: exposes the next value of a Fibonacci
// shift register; advances to it on adv. Assumes SEED is nonzero.
module wdt_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] SEED = 8'hA5,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] next_val
);
    logic [W-1:0] state;

    assign next_val = {state[W-2:0], ^(state & TAPS)};

    // Hold the sequence state; step forward on each accepted clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= SEED;
        else if (adv)      state <= next_val;
    end
endmodule

// File: rtl/wdt_counter.sv
// Main counter: counts up or down on tick, flags expiry at the terminal value,
// then wraps or reloads. Assumes restart has priority over tick.
module wdt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         restart,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         up,
    input  logic         periodic,
    output logic [W-1:0] count,
    output logic         expire
);
    localparam logic [W-1:0] MAXV = '1;

    assign expire = tick && !restart && (up ? (count == MAXV) : (count == '0));

    // Load, reload, or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           count <= MAXV;
        else if (restart)            count <= load_val;
        else if (expire && periodic) count <= load_val;
        else if (tick)               count <= up ? count + 1'b1 : count - 1'b1;
    end
endmodule

// File: rtl/wdog_timer.sv
// Top: register bank, watchdog control, lock and secure-clear decision around
// the prescaler, counter and sequence generator. Assumes one access per cycle.
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          CW        = 8,
    parameter logic [CW-1:0] SEED    = 8'hA5,
    parameter logic [CW-1:0] TAPS    = 8'hB8,
    parameter int          SHIFT_MID = 4,
    parameter int          SHIFT_HI  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          rst_req
);
    logic [DW-1:0] load_q;
    logic [DW-1:0] count_q;
    ctrl_t         ctrl_q;
    logic          irq_q;
    logic          rst_req_q;
    logic [CW-1:0] seq_next;
    logic          tick, expire;
    logic          locked, wr_ctrl, wr_clr, en_rise, wd_active;
    logic          clr_ok, clr_bad, restart, wd_fire, soft_rst;
    logic [DW-1:0] ctrl_rd;

    // Decode bus writes and the watchdog decisions.
    always_comb begin
        locked    = ctrl_q.en && ctrl_q.wd;
        wr_ctrl   = bus_we && (bus_addr == A_CTRL) && !locked;
        wr_clr    = bus_we && (bus_addr == A_CLEAR);
        en_rise   = wr_ctrl && bus_wdata[7] && !ctrl_q.en;
        wd_active = ctrl_q.en && ctrl_q.wd;
        clr_ok    = wr_clr && wd_active && (!ctrl_q.secure || bus_wdata[CW-1:0] == seq_next);
        clr_bad   = wr_clr && wd_active && ctrl_q.secure && (bus_wdata[CW-1:0] != seq_next);
        restart   = en_rise || clr_ok;
        wd_fire   = wd_active && (expire || clr_bad);
        soft_rst  = wd_fire && !ctrl_q.wd_irq;
    end

    wdt_prescale #(.SHIFT_MID(SHIFT_MID), .SHIFT_HI(SHIFT_HI)) i_pre (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .restart(restart),
        .run(ctrl_q.en), .sel(ctrl_q.presc), .tick(tick)
    );

    wdt_counter #(.W(DW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .restart(restart),
        .load_val(load_q), .tick(tick), .up(ctrl_q.up),
        .periodic(ctrl_q.periodic), .count(count_q), .expire(expire)
    );

    wdt_lfsr #(.W(CW), .SEED(SEED), .TAPS(TAPS)) i_seq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .adv(clr_ok && ctrl_q.secure), .next_val(seq_next)
    );

    // Load register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                   load_q <= '0;
        else if (bus_we && bus_addr == A_LOAD)    load_q <= bus_wdata;
    end

    // Control register, frozen while the watchdog runs.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) ctrl_q <= '0;
        else if (wr_ctrl)       ctrl_q <= word_to_ctrl(16'(bus_wdata));
    end

    // Interrupt level: set on expiry or failed secure clear, cleared by clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)      irq_q <= 1'b0;
        else if (expire || wd_fire)  irq_q <= 1'b1;
        else if (wr_clr)             irq_q <= 1'b0;
    end

    // Reset request pulse, coincident with the internal soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req_q <= 1'b0;
        else        rst_req_q <= soft_rst;
    end

    assign ctrl_rd = DW'(ctrl_to_word(ctrl_q));

    // Read multiplexer; clear register and idle bus read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                A_LOAD:  bus_rdata = load_q;
                A_COUNT: bus_rdata = count_q;
                A_CTRL:  bus_rdata = ctrl_rd;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq     = irq_q;
    assign rst_req = rst_req_q;
endmodule

// File: rtl/wdog_timer_chk.sv
// Checker: temporal properties of the watchdog timer, bound to every instance.
// Assumes it sees the top's count and packed control word.
module wdog_timer_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic          bus_re,
    input logic [1:0]    bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          rst_req,
    input logic [DW-1:0] count_q,
    input logic [DW-1:0] ctrl_rd
);
    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8
    rst_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count_q == '1 && ctrl_rd == '0));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 2'd2) |-> (bus_rdata[DW-1:9] == '0 && !bus_rdata[0]));

    // R2
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 2'd3) |-> (bus_rdata == '0));

    // R12
    ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[7] && ctrl_rd[5]) |=> ($stable(ctrl_rd) || rst_req));

    // R3
    hold_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[7] && !(bus_we && bus_addr == 2'd2)) |=> $stable(count_q));
endmodule

bind wdog_timer wdog_timer_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rst_req(rst_req),
    .count_q(count_q), .ctrl_rd(ctrl_rd)
);

// File: tb/test_wdog_timer.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares them.
module test_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0, re = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 rst_req
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    function automatic logic [7:0] seq_step(logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    // Monitor: mid low phase, pop one expected item and compare.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = sb.pop_front();
                act = (it.kind == 0) ? rdata : (it.kind == 1) ? {15'b0, irq} : {15'b0, rst_req};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic op_read(input logic [1:0] a, input logic [15:0] e, input string tag);
        re = 1'b1; addr = a;
        sb.push_back('{0, e, tag});
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic op_sig(input int kind, input logic [15:0] e, input string tag);
        sb.push_back('{kind, e, tag});
        @(negedge clk);
    endtask

    task automatic op_write(input logic [1:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic op_idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_raw(input logic [1:0] a, output logic [15:0] v);
        re = 1'b1; addr = a;
        #5 v = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        logic [7:0]  s1, s2;
        @(negedge clk);
        do_reset();

        // R1 reset state
        op_read(2'd0, 16'h0000, "R1 load");
        op_read(2'd1, 16'hFFFF, "R1 count");
        op_read(2'd2, 16'h0000, "R1 ctrl");
        op_sig(1, 16'h0, "R1 irq");
        op_sig(2, 16'h0, "R1 rst_req");

        // R2 map, reserved bits, read-only count, write-only clear
        op_write(2'd2, 16'hFE01);
        op_read(2'd2, 16'h0000, "R2 reserved ctrl bits");
        op_write(2'd1, 16'h1234);
        op_read(2'd1, 16'hFFFF, "R2 count write ignored");
        op_read(2'd3, 16'h0000, "R2 clear reads zero");
        op_write(2'd0, 16'h0005);
        op_read(2'd0, 16'h0005, "R2 load readback");

        // R3/R5 down, /1, free-run
        op_write(2'd2, 16'h0080);
        op_read(2'd1, 16'h0005, "R3 load on enable");
        op_read(2'd1, 16'h0004, "R5 step");
        op_idle(3);
        op_read(2'd1, 16'h0000, "R5 at zero");
        op_read(2'd1, 16'hFFFF, "R5 free-run wrap");
        op_sig(1, 16'h1, "R7 irq set");
        op_write(2'd3, 16'h0000);
        op_sig(1, 16'h0, "R7 irq cleared");
        op_write(2'd2, 16'h0000);
        read_raw(2'd1, held);
        op_idle(3);
        op_read(2'd1, held, "R3 hold while disabled");

        // R4/R5 down, /16, periodic
        op_write(2'd0, 16'h0002);
        op_write(2'd2, 16'h00C4);
        op_idle(15);
        op_read(2'd1, 16'h0002, "R4 no step before 16");
        op_read(2'd1, 16'h0001, "R4 step at 16");
        op_idle(30);
        op_read(2'd1, 16'h0000, "R4 zero");
        op_read(2'd1, 16'h0002, "R5 periodic reload");
        op_sig(1, 16'h1, "R7 irq periodic");

        // R6 up, prescale 11 as /1, free-run
        op_write(2'd3, 16'h0000);
        op_write(2'd2, 16'h0000);
        op_write(2'd0, 16'hFFFD);
        op_write(2'd2, 16'h018C);
        op_read(2'd1, 16'hFFFD, "R6 load");
        op_read(2'd1, 16'hFFFE, "R4 code 11 steps each clock");
        op_read(2'd1, 16'hFFFF, "R6 max");
        op_read(2'd1, 16'h0000, "R6 wrap to zero");
        op_sig(1, 16'h1, "R7 irq up");

        // R6 up periodic
        op_write(2'd3, 16'h0000);
        op_write(2'd2, 16'h0000);
        op_write(2'd0, 16'hFFFE);
        op_write(2'd2, 16'h01C0);
        op_read(2'd1, 16'hFFFE, "R6 periodic load");
        op_read(2'd1, 16'hFFFF, "R6 periodic max");
        op_read(2'd1, 16'hFFFE, "R6 periodic reload");

        // R8/R12 watchdog reset action with lock
        op_write(2'd3, 16'h0000);
        op_write(2'd2, 16'h0000);
        op_write(2'd0, 16'h0003);
        op_write(2'd2, 16'h00A0);
        op_write(2'd2, 16'h0000);
        op_read(2'd2, 16'h00A0, "R12 ctrl locked");
        op_read(2'd1, 16'h0001, "R12 still counting");
        op_read(2'd1, 16'h0000, "R8 at zero");
        op_sig(2, 16'h1, "R8 reset pulse");
        op_read(2'd2, 16'h0000, "R8 ctrl back to reset");
        op_read(2'd1, 16'hFFFF, "R8 count back to reset");
        op_sig(2, 16'h0, "R8 pulse one cycle");

        // R9/R10 watchdog interrupt action, plain clear restarts
        op_write(2'd0, 16'h0004);
        op_write(2'd2, 16'h00A2);
        op_idle(2);
        op_write(2'd3, 16'h0077);
        op_read(2'd1, 16'h0004, "R10 clear restarts");
        op_read(2'd1, 16'h0003, "R10 counting after restart");
        op_idle(2);
        op_read(2'd1, 16'h0000, "R9 at zero");
        op_sig(1, 16'h1, "R9 irq instead of reset");
        op_sig(2, 16'h0, "R9 no reset");
        do_reset();

        // R11 secure clear, reset action
        s1 = seq_step(8'hA5);
        s2 = seq_step(s1);
        op_write(2'd0, 16'h0010);
        op_write(2'd2, 16'h00B0);
        op_idle(2);
        op_write(2'd3, {8'h00, s1});
        op_read(2'd1, 16'h0010, "R11 matching clear restarts");
        op_write(2'd3, {8'h00, s2 ^ 8'h01});
        op_sig(2, 16'h1, "R11 mismatch fires reset");
        op_read(2'd2, 16'h0000, "R11 ctrl reset after mismatch");

        // R11 secure clear, interrupt action
        op_write(2'd0, 16'h0010);
        op_write(2'd2, 16'h00B2);
        op_write(2'd3, {8'h00, s1 ^ 8'hFF});
        op_sig(1, 16'h1, "R11 mismatch raises irq");
        op_sig(2, 16'h0, "R11 mismatch no reset with irq option");

        op_idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule